// File: doc/BRIEF.md
# Backend Memory Access Timeout Guard

This block watches each memory access that a remote terminal core makes to its backend. In the cycle an access begins, the block looks at two write-type qualifiers. If either a command-word write or a status-word write is in progress, it arms a short limit of 10 µs. Otherwise it arms a long limit of 19.5 µs. Both limits are counted in clock cycles of the parameterised clock. If the backend acknowledges before the limit runs out, the access closes quietly. If it does not, the block emits a one-cycle abort that terminates the access and sets a sticky memory-interface error. That error later becomes bit 8 of the transfer status word.

The error stays set until the surrounding transfer is reported finished. After that it clears, ready for the next transfer. All pins are plain control and status levels or pulses, with no data stream. The short limit exists so that a command-word write and the first data-word fetch can both complete inside the 20 µs that a status word takes to transmit.

Top module: `bmw_access_watchdog`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, acc_abort and mem_err are both 0.
- R2: If acc_start is high in cycle 0 and cmd_wr and stat_wr are both low, and acc_ack stays low, then acc_abort is high in exactly cycle LONG_CYC+1. Here LONG_CYC = floor(CLK_KHZ*19500/1e6), which is 19.5 µs.
- R3: If acc_start is high in cycle 0 and cmd_wr or stat_wr is high in that same cycle, the limit is SHORT_CYC = floor(CLK_KHZ*10000/1e6), which is 10 µs. acc_abort is then high in exactly cycle SHORT_CYC+1.
- R4: cmd_wr and stat_wr are sampled only in the start cycle. Changing them later does not change the limit of the access already running.
- R5: An acc_ack in any cycle from 1 to the limit (the last cycle included) completes the access. No acc_abort follows, and mem_err does not change.
- R6: acc_abort is a single-cycle pulse. mem_err becomes 1 in the same cycle as acc_abort, and it never rises without acc_abort.
- R7: mem_err stays 1 until a cycle in which xfer_done is high, and reads 0 in the following cycle. If xfer_done coincides with a new timeout, the flag stays 1.
- R8: An acc_start during a pending access drops that access and restarts timing with the limit chosen by the qualifiers of the new start cycle.
- R9: acc_ack has no effect while no access is pending, or in the start cycle itself. Outputs stay unchanged, and a following access still runs to its full limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_start | input | 1 | One-cycle pulse: a backend access begins |
| acc_ack | input | 1 | Backend completed the pending access |
| cmd_wr | input | 1 | Access is a command-word write (selects short limit) |
| stat_wr | input | 1 | Access is a status-word write (selects short limit) |
| xfer_done | input | 1 | End of transfer; clears the sticky error |
| acc_abort | output | 1 | One-cycle pulse terminating a timed-out access |
| mem_err | output | 1 | Sticky memory-interface error flag |

## Verification
The bench targets the exact cycle of expiry for both limits. A design that is off by one register would abort a cycle early or late, and would also reject or accept an acknowledge that arrives in the final cycle. It raises and drops the qualifiers after the start cycle to catch a design that re-evaluates the limit on the fly. It restarts a pending access to catch timers that keep the old count. It also lines up end-of-transfer with a fresh timeout, where a design that lets the clear win would lose an error that the status word must report.

// File: rtl/bmw_pkg.sv
package bmw_pkg;
  typedef enum logic {ACC_NORMAL = 1'b0, ACC_SHORT = 1'b1} acc_kind_t;

  // Cycles in a window of ns nanoseconds at khz kilohertz, never below 1.
  function automatic int cyc_of(input longint khz, input longint ns);
    longint c;
    c = (khz * ns) / 64'd1_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction
endpackage

// File: rtl/bmw_limit_sel.sv
module bmw_limit_sel import bmw_pkg::*; #(
  parameter int CW        = 12,
  parameter int LONG_CYC  = 3900,
  parameter int SHORT_CYC = 2000
) (
  input  logic          cmd_wr,
  input  logic          stat_wr,
  output logic [CW-1:0] limit
);
  acc_kind_t kind;

  always_comb begin
    kind  = (cmd_wr || stat_wr) ? ACC_SHORT : ACC_NORMAL;
    limit = (kind == ACC_SHORT) ? CW'(SHORT_CYC) : CW'(LONG_CYC);
  end
endmodule

// File: rtl/bmw_countdown.sv
module bmw_countdown #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] limit,
  input  logic          ack,
  output logic          busy,
  output logic          expire
);
  logic [CW-1:0] left_q;

  // Expiry: last waiting cycle reached with no acknowledge seen.
  assign expire = busy && (left_q == '0) && !ack && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left_q <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      left_q <= limit - 1'b1;
    end else if (busy) begin
      if (ack || left_q == '0) begin
        busy <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/bmw_err_flag.sv
module bmw_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/bmw_access_watchdog.sv
module bmw_access_watchdog import bmw_pkg::*; #(
  parameter int CLK_KHZ  = 200_000,
  parameter int LONG_NS  = 19_500,
  parameter int SHORT_NS = 10_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_start,
  input  logic acc_ack,
  input  logic cmd_wr,
  input  logic stat_wr,
  input  logic xfer_done,
  output logic acc_abort,
  output logic mem_err
);
  localparam int LONG_CYC  = cyc_of(CLK_KHZ, LONG_NS);
  localparam int SHORT_CYC = cyc_of(CLK_KHZ, SHORT_NS);
  localparam int MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1);

  logic [CW-1:0] limit;
  logic          busy;
  logic          expire;

  bmw_limit_sel #(.CW(CW), .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_sel (
    .cmd_wr (cmd_wr),
    .stat_wr(stat_wr),
    .limit  (limit)
  );

  bmw_countdown #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (acc_start),
    .limit (limit),
    .ack   (acc_ack),
    .busy  (busy),
    .expire(expire)
  );

  bmw_err_flag u_err (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (expire),
    .clr  (xfer_done),
    .flag (mem_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_abort <= 1'b0;
    else        acc_abort <= expire;
  end
endmodule

// File: rtl/bmw_access_watchdog_chk.sv
module bmw_access_watchdog_chk #(
  parameter int LONG_CYC  = 3900,
  parameter int SHORT_CYC = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic acc_start,
  input logic acc_ack,
  input logic cmd_wr,
  input logic stat_wr,
  input logic xfer_done,
  input logic acc_abort,
  input logic mem_err
);
  int   since;
  int   lim;
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= 0;
      lim   <= LONG_CYC;
      pend  <= 1'b0;
    end else if (acc_start) begin
      since <= 1;
      lim   <= (cmd_wr || stat_wr) ? SHORT_CYC : LONG_CYC;
      pend  <= 1'b1;
    end else begin
      if (since < 32'h3fff_ffff) since <= since + 1;
      if (pend && (acc_ack || since == lim)) pend <= 1'b0;
    end
  end

  AST_ABORT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_abort |-> (since == lim + 1)); // R2
  AST_ACK_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && acc_ack && !acc_start) |=> !acc_abort); // R5
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_abort |=> !acc_abort); // R6
  AST_ERR_WITH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_abort |-> mem_err); // R6
  AST_ERR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_err) |-> acc_abort); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_err && !xfer_done) |=> mem_err); // R7
endmodule

bind bmw_access_watchdog bmw_access_watchdog_chk #(
  .LONG_CYC (LONG_CYC),
  .SHORT_CYC(SHORT_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_start(acc_start),
  .acc_ack  (acc_ack),
  .cmd_wr   (cmd_wr),
  .stat_wr  (stat_wr),
  .xfer_done(xfer_done),
  .acc_abort(acc_abort),
  .mem_err  (mem_err)
);

// File: tb/bmw_access_watchdog_tb.sv
module bmw_access_watchdog_tb;
  localparam int KHZ = 2000;
  localparam int L   = 39;  // 2000 kHz * 19.5 us
  localparam int S   = 20;  // 2000 kHz * 10 us

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_start = 1'b0, acc_ack = 1'b0, cmd_wr = 1'b0, stat_wr = 1'b0, xfer_done = 1'b0;
  logic acc_abort, mem_err;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  bmw_access_watchdog #(.CLK_KHZ(KHZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_ack(acc_ack),
    .cmd_wr(cmd_wr), .stat_wr(stat_wr), .xfer_done(xfer_done),
    .acc_abort(acc_abort), .mem_err(mem_err)
  );

  // Behavioural reference: elapsed cycles counted upward against a limit.
  int m_busy = 0, m_elapsed = 0, m_lim = 0, m_abort = 0, m_err = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_elapsed = 0; m_abort = 0; m_err = 0;
    end else begin
      m_abort = 0;
      if (acc_start) begin
        m_busy = 1; m_elapsed = 0; m_lim = (cmd_wr || stat_wr) ? S : L;
      end else if (m_busy == 1) begin
        m_elapsed++;
        if (acc_ack) m_busy = 0;
        else if (m_elapsed == m_lim) begin
          m_busy = 0; m_abort = 1; m_err = 1;
        end
      end
      if (xfer_done && m_abort == 0) m_err = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check({cur_req, " abort"}, int'(acc_abort), m_abort);
      check({cur_req, " err"}, int'(mem_err), m_err);
    end
  end

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: actual=hang expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Start in cycle 0; returns at the negedge showing cycle 1.
  task automatic start(input logic c, input logic t);
    acc_start = 1'b1; cmd_wr = c; stat_wr = t;
    @(negedge clk);
    acc_start = 1'b0; cmd_wr = 1'b0; stat_wr = 1'b0;
  endtask

  task automatic abort_cycle(output int k, input int max);
    k = 1;
    while (!acc_abort && k < max) begin @(negedge clk); k++; end
  endtask

  task automatic clear_err;
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0; @(negedge clk);
  endtask

  int k;
  initial begin
    @(negedge clk);
    check("R1 reset abort", int'(acc_abort), 0);
    check("R1 reset err", int'(mem_err), 0);
    tick(2);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post abort", int'(acc_abort), 0);
    check("R1 post err", int'(mem_err), 0);

    cur_req = "R2";
    start(1'b0, 1'b0);
    abort_cycle(k, L + 10);
    check("R2 long expiry cycle", k, L + 1);
    check("R6 err with abort", int'(mem_err), 1);
    @(negedge clk);
    check("R6 abort one cycle", int'(acc_abort), 0);
    tick(3);
    check("R7 sticky", int'(mem_err), 1);
    cur_req = "R7";
    clear_err();
    check("R7 cleared", int'(mem_err), 0);

    cur_req = "R3";
    start(1'b1, 1'b0);
    abort_cycle(k, L + 10);
    check("R3 short via cmd_wr", k, S + 1);
    clear_err();
    start(1'b0, 1'b1);
    abort_cycle(k, L + 10);
    check("R3 short via stat_wr", k, S + 1);
    clear_err();

    cur_req = "R4";
    start(1'b0, 1'b0);
    tick(2); cmd_wr = 1'b1; stat_wr = 1'b1;
    tick(5); cmd_wr = 1'b0; stat_wr = 1'b0;
    k = 8;
    while (!acc_abort && k < L + 10) begin @(negedge clk); k++; end
    check("R4 late qualifier ignored", k, L + 1);
    clear_err();
    start(1'b1, 1'b0);
    cmd_wr = 1'b0;
    abort_cycle(k, L + 10);
    check("R4 short kept", k, S + 1);
    clear_err();

    cur_req = "R5";
    start(1'b0, 1'b0);
    tick(9); acc_ack = 1'b1; @(negedge clk); acc_ack = 1'b0;
    tick(L + 5);
    check("R5 mid ack no err", int'(mem_err), 0);
    start(1'b1, 1'b0);           // cycle 1 observed here
    tick(S - 1); acc_ack = 1'b1; // drive during cycle S
    @(negedge clk); acc_ack = 1'b0;
    check("R5 last-cycle ack no abort", int'(acc_abort), 0);
    tick(4);
    check("R5 last-cycle ack no err", int'(mem_err), 0);

    cur_req = "R8";
    start(1'b0, 1'b0);
    tick(10);
    start(1'b0, 1'b1);
    abort_cycle(k, L + 10);
    check("R8 restart uses new short limit", k, S + 1);
    clear_err();
    start(1'b1, 1'b0);
    tick(5);
    start(1'b0, 1'b0);
    abort_cycle(k, L + 10);
    check("R8 restart uses new long limit", k, L + 1);
    clear_err();

    cur_req = "R9";
    acc_ack = 1'b1; tick(4); acc_ack = 1'b0;
    check("R9 idle ack abort", int'(acc_abort), 0);
    check("R9 idle ack err", int'(mem_err), 0);
    acc_ack = 1'b1; start(1'b1, 1'b0); acc_ack = 1'b0;
    abort_cycle(k, L + 10);
    check("R9 start-cycle ack ignored", k, S + 1);

    cur_req = "R7";
    start(1'b1, 1'b0);           // error still set from previous
    tick(S - 1); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    check("R7 timeout beats clear abort", int'(acc_abort), 1);
    check("R7 timeout beats clear err", int'(mem_err), 1);
    clear_err();
    check("R7 final clear", int'(mem_err), 0);

    tick(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule